// File: doc/BRIEF.md
# Link Presence and Loss-of-Sync Notifier

This block sits next to one serial link port and keeps track of whether the link partner is there. Software can poll two status outputs. It can also rely on a level interrupt and a single-cycle port-write request, which together report insertion and extraction events. Two kinds of event set a notification status bit:

- a link that initializes while the port is locked out;
- lost lane synchronization or alignment while the port is disabled.

Software clears that bit by writing one to it.

The block also governs two down-counting timers. The acknowledgement timeout timer is frozen while lane synchronization is absent. When synchronization returns, it reloads from its programmed value. The packet time-to-live timer keeps counting whatever the lanes are doing. A comparator raises a flag when the time-to-live setting is not longer than the silence setting, because that combination can lose packets. Lane status inputs are assumed to be already in this clock domain.

Top module: `link_presence_notifier`

## Requirements
- R1: `portOk` equals `linkInit` and `portUninit` equals its inverse, each delayed by one clock. Out of reset `portOk` is 0 and `portUninit` is 1.
- R2: `irq` is high in the same cycle whenever `notifyStat`, `notifyEn` and either `cfgLockout` or `cfgDisable` are all 1. Otherwise it is 0.
- R3: A rise of (`linkInit` AND `cfgLockout`) sets `notifyStat`. It also produces a `portWriteReq` pulse exactly one cycle long, one clock later. Holding the condition gives no further pulse. Each later re-initialization while locked out gives one more pulse.
- R4: A fall of (`laneSync` AND `laneAlign`) while `cfgDisable` and `notifyEn` are 1 sets `notifyStat` and pulses `portWriteReq` one clock later. With `cfgDisable` at 0 it does neither.
- R5: A fall of `laneSync` pulses `syncRestart` for one cycle and sets `inErrStopped`, both one clock later. `inErrStopped` clears one clock after `laneSync` rises again.
- R6: While `laneSync` is 0, `ackCount` does not change even when `tick` is 1.
- R7: While armed and nonzero, `ttlCount` drops by one on each clock with `tick` high, with or without lane sync. It pulses `ttlExpired` for one cycle on reaching 0.
- R8: `cfgBad` is 1 exactly when `ttlVal` is less than or equal to `silenceVal`. It is combinational.
- R9: `notifyClr` high clears `notifyStat` one clock later. `irq` therefore falls even with lockout still set. A new setting event in the same cycle wins over the clear.
- R10: `ackArm` loads `ackVal` into `ackCount`. The timer runs only when the loaded value is nonzero. A rise of `laneSync` reloads `ackVal` while the timer runs. A decrement from 1 to 0 pulses `ackTimeout` for one cycle and stops the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer step enable |
| laneSync | input | 1 | Lane synchronization status |
| laneAlign | input | 1 | Lane alignment status |
| linkInit | input | 1 | Link initialized |
| cfgLockout | input | 1 | Port locked out |
| cfgDisable | input | 1 | Port disabled by software |
| notifyEn | input | 1 | Notification enable |
| notifyClr | input | 1 | Write-one-to-clear strobe for notification status |
| ackArm | input | 1 | Load acknowledgement timer |
| ttlArm | input | 1 | Load time-to-live timer |
| ackVal | input | W | Acknowledgement timeout value |
| ttlVal | input | W | Time-to-live value |
| silenceVal | input | W | Silence timer value |
| portOk | output | 1 | Link initialized status |
| portUninit | output | 1 | Link uninitialized status |
| irq | output | 1 | Level interrupt |
| portWriteReq | output | 1 | One-cycle port-write request |
| notifyStat | output | 1 | Notification status bit |
| inErrStopped | output | 1 | Input-error-stopped state |
| syncRestart | output | 1 | Synchronization machine restart pulse |
| ackCount | output | W | Acknowledgement timer value |
| ackTimeout | output | 1 | Acknowledgement timeout pulse |
| ttlCount | output | W | Time-to-live timer value |
| ttlExpired | output | 1 | Time-to-live expiry pulse |
| cfgBad | output | 1 | Unsafe time-to-live setting |

## Verification
`irq` and `cfgBad` are combinational, so they are checked in the same cycle as the inputs they depend on. Every other result is registered once and is due at the first rising edge that samples the stimulus. The bench applies its inputs after an edge, waits for the next edge, and samples 1 ns after it. Counter checks count that edge as the step, so a tick applied before edge k shows up as a decrement right after edge k.

// File: rtl/lpn_pkg.sv
package lpn_pkg;
  typedef struct packed {
    logic ackHold;
    logic ackReload;
  } tmr_strobe_t;
endpackage

// File: rtl/lpn_down_timer.sv
module lpn_down_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         reload,
  input  logic         hold,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         running,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      running <= 1'b0;
      expire  <= 1'b0;
    end else if (load) begin
      count   <= loadVal;
      running <= (loadVal != '0);
      expire  <= 1'b0;
    end else if (reload && running) begin
      count  <= loadVal;
      expire <= 1'b0;
    end else if (step && running && !hold) begin
      count <= count - ONE;
      if (count == ONE) begin
        running <= 1'b0;
        expire  <= 1'b1;
      end else begin
        expire <= 1'b0;
      end
    end else begin
      expire <= 1'b0;
    end
  end

  // R6: a held timer keeps its value
  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    hold && !load && !reload |=> $stable(count));
  // R7: an unheld running timer steps down by one
  p_step_dec_r7: assert property (@(posedge clk) disable iff (!rstN)
    step && running && !hold && !load && !reload |=> count == $past(count) - ONE);
  // R10: expiry is a single-cycle pulse
  p_expire_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !expire);
endmodule

// File: rtl/lpn_ctrl.sv
module lpn_ctrl
  import lpn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        laneSync,
  input  logic        laneAlign,
  input  logic        linkInit,
  input  logic        cfgLockout,
  input  logic        cfgDisable,
  input  logic        notifyEn,
  input  logic        notifyClr,
  output logic        portOk,
  output logic        portUninit,
  output logic        irq,
  output logic        portWriteReq,
  output logic        notifyStat,
  output logic        inErrStopped,
  output logic        syncRestart,
  output tmr_strobe_t strobe
);
  logic laneSyncQ, goodQ, lockInitQ;
  logic lockInit, initEdge, good, lossAny, lossSync, errEvt, setEvt;

  always_comb begin
    lockInit = linkInit & cfgLockout;
    initEdge = lockInit & ~lockInitQ;
    good     = laneSync & laneAlign;
    lossAny  = goodQ & ~good;
    lossSync = laneSyncQ & ~laneSync;
    errEvt   = lossAny & cfgDisable & notifyEn;
    setEvt   = initEdge | errEvt;
    irq      = notifyStat & notifyEn & (cfgLockout | cfgDisable);
    strobe.ackHold   = ~laneSync;
    strobe.ackReload = laneSync & ~laneSyncQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneSyncQ    <= 1'b0;
      goodQ        <= 1'b0;
      lockInitQ    <= 1'b0;
      notifyStat   <= 1'b0;
      portWriteReq <= 1'b0;
      syncRestart  <= 1'b0;
      inErrStopped <= 1'b0;
      portOk       <= 1'b0;
      portUninit   <= 1'b1;
    end else begin
      laneSyncQ    <= laneSync;
      goodQ        <= good;
      lockInitQ    <= lockInit;
      portWriteReq <= setEvt;
      syncRestart  <= lossSync;
      portOk       <= linkInit;
      portUninit   <= ~linkInit;
      if (setEvt)         notifyStat <= 1'b1;
      else if (notifyClr) notifyStat <= 1'b0;
      if (lossSync)                    inErrStopped <= 1'b1;
      else if (laneSync && !laneSyncQ) inErrStopped <= 1'b0;
    end
  end

  p_ok_tracks_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> portOk == $past(linkInit));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    notifyClr && !setEvt |=> !notifyStat);
  p_stop_on_loss_r5: assert property (@(posedge clk) disable iff (!rstN)
    lossSync |=> inErrStopped && syncRestart);
  p_set_sticks_r3: assert property (@(posedge clk) disable iff (!rstN)
    initEdge |=> notifyStat && portWriteReq);
endmodule

// File: rtl/lpn_datapath.sv
module lpn_datapath
  import lpn_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  tmr_strobe_t  strobe,
  input  logic         ackArm,
  input  logic         ttlArm,
  input  logic [W-1:0] ackVal,
  input  logic [W-1:0] ttlVal,
  input  logic [W-1:0] silenceVal,
  output logic [W-1:0] ackCount,
  output logic         ackTimeout,
  output logic [W-1:0] ttlCount,
  output logic         ttlExpired,
  output logic         cfgBad
);
  logic ackRunning, ttlRunning;

  lpn_down_timer #(.W(W)) ackTmr_i (
    .clk(clk), .rstN(rstN), .load(ackArm), .loadVal(ackVal),
    .reload(strobe.ackReload), .hold(strobe.ackHold), .step(tick),
    .count(ackCount), .running(ackRunning), .expire(ackTimeout));

  lpn_down_timer #(.W(W)) ttlTmr_i (
    .clk(clk), .rstN(rstN), .load(ttlArm), .loadVal(ttlVal),
    .reload(1'b0), .hold(1'b0), .step(tick),
    .count(ttlCount), .running(ttlRunning), .expire(ttlExpired));

  assign cfgBad = (ttlVal <= silenceVal);

  // R7: lane status never holds the lifetime timer
  p_ttl_runs_r7: assert property (@(posedge clk) disable iff (!rstN)
    tick && ttlRunning && !ttlArm |=> ttlCount == $past(ttlCount) - W'(1));
  // R6: acknowledgement timer frozen without sync
  p_ack_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackHold && !ackArm |=> $stable(ackCount));
endmodule

// File: rtl/link_presence_notifier.sv
module link_presence_notifier
  import lpn_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         laneSync,
  input  logic         laneAlign,
  input  logic         linkInit,
  input  logic         cfgLockout,
  input  logic         cfgDisable,
  input  logic         notifyEn,
  input  logic         notifyClr,
  input  logic         ackArm,
  input  logic         ttlArm,
  input  logic [W-1:0] ackVal,
  input  logic [W-1:0] ttlVal,
  input  logic [W-1:0] silenceVal,
  output logic         portOk,
  output logic         portUninit,
  output logic         irq,
  output logic         portWriteReq,
  output logic         notifyStat,
  output logic         inErrStopped,
  output logic         syncRestart,
  output logic [W-1:0] ackCount,
  output logic         ackTimeout,
  output logic [W-1:0] ttlCount,
  output logic         ttlExpired,
  output logic         cfgBad
);
  tmr_strobe_t strobe;

  lpn_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .laneSync(laneSync), .laneAlign(laneAlign),
    .linkInit(linkInit), .cfgLockout(cfgLockout), .cfgDisable(cfgDisable),
    .notifyEn(notifyEn), .notifyClr(notifyClr), .portOk(portOk),
    .portUninit(portUninit), .irq(irq), .portWriteReq(portWriteReq),
    .notifyStat(notifyStat), .inErrStopped(inErrStopped),
    .syncRestart(syncRestart), .strobe(strobe));

  lpn_datapath #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe),
    .ackArm(ackArm), .ttlArm(ttlArm), .ackVal(ackVal), .ttlVal(ttlVal),
    .silenceVal(silenceVal), .ackCount(ackCount), .ackTimeout(ackTimeout),
    .ttlCount(ttlCount), .ttlExpired(ttlExpired), .cfgBad(cfgBad));
endmodule

// File: tb/link_presence_notifier_tb.sv
module link_presence_notifier_tb_top;
  localparam int W = 16;
  logic clk = 1'b0, rstN = 1'b0;
  logic tick = 0, laneSync = 1, laneAlign = 1, linkInit = 0;
  logic cfgLockout = 1, cfgDisable = 0, notifyEn = 1, notifyClr = 0;
  logic ackArm = 0, ttlArm = 0;
  logic [W-1:0] ackVal = 5, ttlVal = 20, silenceVal = 19;
  logic portOk, portUninit, irq, portWriteReq, notifyStat, inErrStopped, syncRestart;
  logic [W-1:0] ackCount, ttlCount;
  logic ackTimeout, ttlExpired, cfgBad;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  link_presence_notifier #(.W(W)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // {linkInit, lockout, enable, clear, expOk, expPw, expStat, expIrq}
  localparam logic [7:0] VEC [0:9] = '{
    8'b0110_0000, 8'b1110_1111, 8'b1110_1011, 8'b1111_1000, 8'b0110_0000,
    8'b1110_1111, 8'b1100_1010, 8'b1110_1011, 8'b0010_0010, 8'b1010_1010};

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1; #0;
    chk("R1 reset portUninit", portUninit, 1);
    chk("R1 reset portOk", portOk, 0);
    chk("R3 reset pw", portWriteReq, 0);
    chk("R9 reset stat", notifyStat, 0);
    // table for R1 R2 R3 R9
    for (int i = 0; i < 10; i++) begin
      {linkInit, cfgLockout, notifyEn, notifyClr} = VEC[i][7:4];
      step();
      chk("R1 portOk", portOk, VEC[i][3]);
      chk("R3 portWriteReq", portWriteReq, VEC[i][2]);
      chk("R9 notifyStat", notifyStat, VEC[i][1]);
      chk("R2 irq", irq, VEC[i][0]);
    end
    notifyClr = 0;
    // R9 set wins over clear
    cfgLockout = 1; linkInit = 0; step();
    linkInit = 1; notifyClr = 1; step();
    chk("R9 set beats clear", notifyStat, 1);
    chk("R3 pw on reinit", portWriteReq, 1);
    step();
    chk("R9 clear applied", notifyStat, 0);
    chk("R9 irq falls with lockout held", irq, 0);
    notifyClr = 0; cfgLockout = 0; linkInit = 0;
    // R4 disabled port, loss of alignment
    cfgDisable = 1; laneAlign = 0; step();
    chk("R4 pw on align loss", portWriteReq, 1);
    chk("R4 stat on align loss", notifyStat, 1);
    chk("R2 irq while disabled", irq, 1);
    step();
    chk("R4 pw single", portWriteReq, 0);
    laneSync = 0; step();
    chk("R4 no repeat event", portWriteReq, 0);
    chk("R5 stopped", inErrStopped, 1);
    chk("R5 restart pulse", syncRestart, 1);
    step();
    chk("R5 restart ends", syncRestart, 0);
    laneSync = 1; laneAlign = 1; notifyClr = 1; step();
    chk("R5 stop cleared", inErrStopped, 0);
    notifyClr = 0; cfgDisable = 0; step();
    laneSync = 0; step();
    chk("R4 no pw when enabled port", portWriteReq, 0);
    chk("R4 no stat when enabled port", notifyStat, 0);
    laneSync = 1; step();
    // R8
    ttlVal = 20; silenceVal = 20; #1 chk("R8 equal", cfgBad, 1);
    silenceVal = 25; #1 chk("R8 less", cfgBad, 1);
    silenceVal = 19; #1 chk("R8 greater", cfgBad, 0);
    // R6 R7 R10 timers
    ackArm = 1; ttlArm = 1; step();
    ackArm = 0; ttlArm = 0;
    chk("R10 arm", ackCount, 5);
    chk("R7 arm", ttlCount, 20);
    tick = 1; step(); step();
    chk("R10 counting", ackCount, 3);
    laneSync = 0; step(); step(); step();
    chk("R6 frozen", ackCount, 3);
    chk("R7 runs through loss", ttlCount, 15);
    laneSync = 1; tick = 0; step();
    chk("R10 reload on regain", ackCount, 5);
    tick = 1;
    for (int k = 0; k < 4; k++) step();
    chk("R10 near zero", ackCount, 1);
    chk("R10 no early timeout", ackTimeout, 0);
    step();
    chk("R10 zero", ackCount, 0);
    chk("R10 timeout pulse", ackTimeout, 1);
    chk("R7 ttl value", ttlCount, 10);
    tick = 0; step();
    chk("R10 timeout single", ackTimeout, 0);
    tick = 1;
    for (int k = 0; k < 9; k++) step();
    chk("R7 ttl one", ttlCount, 1);
    chk("R7 no early expiry", ttlExpired, 0);
    step();
    chk("R7 expiry pulse", ttlExpired, 1);
    chk("R7 ttl zero", ttlCount, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule